// File: doc/BRIEF.md
# Byte Memory with Hidden Single-Error Correction

This block is a synchronous byte-wide memory whose every stored byte is silently guarded by four Hamming check bits. A write encodes the incoming byte, then puts the byte in a data array and the four check bits in a separate check array at the same word address. A read takes both back out, computes a syndrome, flips the one bit it names if it names one, and returns the repaired byte. The port looks like a plain byte memory: active-low chip select, write strobe and output enable. There are no error flags and no check-bit pins, so the block can stand in for an unprotected memory of the same shape.

The data bus is split into an input byte, an output byte and an output-drive qualifier. The qualifier marks the cycles in which a pad-level driver would leave high impedance. A test-only injection input XORs a 12-bit mask into the stored codeword at the current address. This lets a bench plant faults in any bit position. A repaired read never writes the fix back. A planted fault stays in the array until the next write to that word.

Top module: `byte_ecc_ram`

## Requirements
- R1: A write stores a byte at an address. A later fault-free read of that address returns the same byte on `dq_o`, one clock after the read cycle.
- R2: The stored codeword has 12 positions, numbered 1 to 12. Check bits sit at positions 1, 2, 4 and 8, and the data bits d0..d7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. Injection mask bit k flips position k+1. A single flipped bit in any of the 12 positions is corrected on read. A flipped check bit leaves the data unchanged.
- R3: A correction is not written back. After one planted fault and a read, a second planted fault in another position gives a double error. A read then returns the word produced by flipping the position that the syndrome (the XOR of the positions of all set bits) names, when that syndrome is 1 to 12. When the syndrome is 13 to 15, the read returns the raw stored data bits.
- R4: A write replaces the whole codeword, so faults planted at that address before it no longer affect reads.
- R5: With `ce_n` high, `dq_oe` is low after the next clock, and a write strobe has no effect on the contents.
- R6: A cycle with `ce_n` low, `we_n` high and `oe_n` low is a read. `dq_oe` is high after that clock edge, with the corrected byte on `dq_o`.
- R7: A cycle with `ce_n` low and `we_n` low is a write, whatever `oe_n` is. After it, `dq_oe` is low.
- R8: A cycle with `ce_n` low and both `we_n` and `oe_n` high leaves `dq_oe` low after the clock.
- R9: While reset is asserted, and right after it, `dq_oe` is low.
- R10: Injection applies only in a cycle that is not a write. In a write cycle, the written codeword wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address (18 for the full 256K-word array) |
| dq_i | input | 8 | Write data byte |
| dq_o | output | 8 | Corrected read data byte |
| dq_oe | output | 1 | High when the data bus would be driven |
| inj_en | input | 1 | Test-only fault injection strobe |
| inj_mask | input | 12 | Codeword positions to flip; bit k is position k+1 |

## Verification
Directed runs place a single fault at each of the 12 codeword positions, one after another, over a byte with mixed bits. A miss in any data position or check position shows up as a wrong byte. A second fault planted on top of an earlier one tells a design that writes back apart from one that does not, because the two predict different miscorrected bytes. The control-pin combinations are each tried after a read that left the bus driven. Random traffic over a small set of reused addresses then mixes writes, single and double faults, and reads, and compares each read with a bench decoder that finds the syndrome by XORing position numbers.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int BYTE_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = BYTE_W + CHK_W;

  // check bit i covers every codeword position whose index has bit i set
  function automatic logic [CHK_W-1:0] ecc_check(input logic [BYTE_W-1:0] d);
    logic [CHK_W-1:0] c;
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[3] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  // codeword bit k holds position k+1
  function automatic logic [CW_W-1:0] ecc_pack(input logic [BYTE_W-1:0] d,
                                               input logic [CHK_W-1:0]  c);
    return {d[7:4], c[3], d[3:1], c[2], d[0], c[1:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] ecc_data_of(input logic [CW_W-1:0] cw);
    return {cw[11:8], cw[6:4], cw[2]};
  endfunction

  function automatic logic [CHK_W-1:0] ecc_chk_of(input logic [CW_W-1:0] cw);
    return {cw[7], cw[3], cw[1], cw[0]};
  endfunction

  function automatic logic [CHK_W-1:0] ecc_syndrome(input logic [BYTE_W-1:0] d,
                                                    input logic [CHK_W-1:0]  c);
    return ecc_check(d) ^ c;
  endfunction

  function automatic logic [BYTE_W-1:0] ecc_fix(input logic [BYTE_W-1:0] d,
                                                input logic [CHK_W-1:0]  c);
    logic [CHK_W-1:0] s;
    logic [CW_W-1:0]  cw;
    s  = ecc_syndrome(d, c);
    cw = ecc_pack(d, c);
    for (int k = 0; k < CW_W; k++) begin
      if (s == CHK_W'(k + 1)) cw[k] = ~cw[k];
    end
    return ecc_data_of(cw);
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  always_comb chk = ecc_check(data);
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  logic [BYTE_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [CHK_W-1:0]  syn,
  output logic [BYTE_W-1:0] fixed
);
  always_comb begin
    syn   = ecc_syndrome(raw_data, raw_chk);
    fixed = ecc_fix(raw_data, raw_chk);
  end
endmodule

// File: rtl/cw_store.sv
module cw_store
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_fire,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic              inj_fire,
  input  logic [CW_W-1:0]   inj_mask,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] dat_mem [DEPTH];
  logic [CHK_W-1:0]  chk_mem [DEPTH];
  logic [BYTE_W-1:0] flip_dat;
  logic [CHK_W-1:0]  flip_chk;

  always_comb begin
    flip_dat = ecc_data_of(inj_mask);
    flip_chk = ecc_chk_of(inj_mask);
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      dat_mem[addr] <= wr_data;
      chk_mem[addr] <= wr_chk;
    end else if (inj_fire) begin
      dat_mem[addr] <= dat_mem[addr] ^ flip_dat;
      chk_mem[addr] <= chk_mem[addr] ^ flip_chk;
    end
  end

  assign rd_data = dat_mem[addr];
  assign rd_chk  = chk_mem[addr];
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [BYTE_W-1:0] fix_byte,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe
);
  always_comb begin
    wr_fire = !ce_n && !we_n;
    rd_fire = !ce_n &&  we_n && !oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe <= 1'b0;
      dq_o  <= '0;
    end else begin
      dq_oe <= rd_fire;
      if (rd_fire) dq_o <= fix_byte;
    end
  end
endmodule

// File: rtl/byte_ecc_ram.sv
module byte_ecc_ram
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  input  logic              inj_en,
  input  logic [11:0]       inj_mask
);
  logic              wr_fire;
  logic              rd_fire;
  logic              inj_fire;
  logic [CHK_W-1:0]  wr_chk;
  logic [BYTE_W-1:0] raw_byte;
  logic [CHK_W-1:0]  raw_chk;
  logic [CHK_W-1:0]  syn;
  logic [BYTE_W-1:0] fix_byte;

  assign inj_fire = inj_en && !wr_fire;

  ecc_enc u_enc (.data(dq_i), .chk(wr_chk));

  cw_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .addr     (addr),
    .wr_fire  (wr_fire),
    .wr_data  (dq_i),
    .wr_chk   (wr_chk),
    .inj_fire (inj_fire),
    .inj_mask (inj_mask),
    .rd_data  (raw_byte),
    .rd_chk   (raw_chk)
  );

  ecc_dec u_dec (.raw_data(raw_byte), .raw_chk(raw_chk), .syn(syn), .fixed(fix_byte));

  port_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .fix_byte (fix_byte),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
  );
endmodule

// File: rtl/byte_ecc_ram_chk.sv
module byte_ecc_ram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_i,
  input logic [7:0]        dq_o,
  input logic              dq_oe,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic [3:0]        syn,
  input logic [7:0]        raw_byte,
  input logic [7:0]        fix_byte
);
  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R9: assert (!dq_oe);
  end

  assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_oe);

  assert_drive_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && we_n && !oe_n));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !dq_oe);

  assert_out_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> !dq_oe);

  assert_clean_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && syn == 4'd0) |-> fix_byte == raw_byte);

  assert_chk_flip_keeps_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && $countones(syn) == 1) |-> fix_byte == raw_byte);

  assert_write_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire ##1 (rd_fire && addr == $past(addr))) |=> dq_o == $past(dq_i, 2));
endmodule

bind byte_ecc_ram byte_ecc_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .syn(syn),
  .raw_byte(raw_byte), .fix_byte(fix_byte)
);

// File: tb/byte_ecc_ram_tb.sv
module byte_ecc_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_i = '0;
  logic [7:0]    dq_o;
  logic          dq_oe;
  logic          inj_en = 1'b0;
  logic [11:0]   inj_mask = '0;

  int errors = 0;
  int checks = 0;
  logic [11:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_ecc_ram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .inj_en(inj_en), .inj_mask(inj_mask)
  );

  // bench encoder: data fills the non-power-of-two positions, parity by position index
  function automatic logic [11:0] tb_encode(input logic [7:0] d);
    logic [11:0] cw;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= 12; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 4; i++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= 12; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) par ^= cw[p-1];
      cw[(1 << i) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [7:0] tb_decode(input logic [11:0] cw_in);
    logic [11:0] cw;
    logic [7:0]  d;
    int s;
    int k;
    cw = cw_in;
    s = 0;
    for (int p = 1; p <= 12; p++) if (cw[p-1]) s ^= p;
    if (s >= 1 && s <= 12) cw[s-1] = ~cw[s-1];
    k = 0;
    d = '0;
    for (int p = 1; p <= 12; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction

  task automatic cyc(input logic c, input logic w, input logic o, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic ie, input logic [11:0] m);
    ce_n = c; we_n = w; oe_n = o; addr = a; dq_i = d; inj_en = ie; inj_mask = m;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; inj_en = 1'b0;
  endtask

  task automatic chk_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dq_oe got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input logic o);
    cyc(1'b0, 1'b0, o, a, d, 1'b0, '0);
    model[a] = tb_encode(d);
  endtask

  task automatic do_inject(input logic [AW-1:0] a, input logic [11:0] m);
    cyc(1'b1, 1'b1, 1'b1, a, 8'h00, 1'b1, m);
    model[a] = model[a] ^ m;
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a);
    cyc(1'b0, 1'b1, 1'b0, a, 8'h00, 1'b0, '0);
    chk_bit(req, dq_oe, 1'b1);
    chk_byte(req, dq_o, tb_decode(model[a]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    @(negedge clk);
    chk_bit("R9 in reset", dq_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R9 after reset", dq_oe, 1'b0);

    // R1 plain write and read
    do_write(10'd5, 8'hA5, 1'b1);
    do_read("R1", 10'd5);
    chk_byte("R1 literal", dq_o, 8'hA5);

    // R2 every single-bit position
    for (int pos = 0; pos < 12; pos++) begin
      do_write(10'd7, 8'h3C, 1'b1);
      do_inject(10'd7, 12'(1) << pos);
      do_read("R2 single fault", 10'd7);
      chk_byte("R2 literal", dq_o, 8'h3C);
    end

    // R3 no write-back: the second fault stacks on the first
    do_write(10'd9, 8'h5A, 1'b1);
    do_inject(10'd9, 12'h004);
    do_read("R3 first fault", 10'd9);
    do_inject(10'd9, 12'h200);
    do_read("R3 double fault", 10'd9);
    do_read("R3 repeat read", 10'd9);
    do_inject(10'd9, 12'h0C0);
    do_read("R3 syndrome range", 10'd9);

    // R4 write clears the faults
    do_write(10'd9, 8'h5A, 1'b1);
    do_read("R4", 10'd9);
    chk_byte("R4 literal", dq_o, 8'h5A);

    // R5 deselected write has no effect
    cyc(1'b1, 1'b0, 1'b0, 10'd5, 8'hFF, 1'b0, '0);
    chk_bit("R5 deselect", dq_oe, 1'b0);
    do_read("R5 contents kept", 10'd5);
    chk_byte("R5 literal", dq_o, 8'hA5);

    // R7 write with oe_n low
    do_write(10'd11, 8'hC3, 1'b0);
    chk_bit("R7 write quiet", dq_oe, 1'b0);
    do_read("R7 write landed", 10'd11);

    // R8 output disabled
    cyc(1'b0, 1'b1, 1'b1, 10'd11, 8'h00, 1'b0, '0);
    chk_bit("R8 out off", dq_oe, 1'b0);

    // R10 write beats injection in the same cycle
    cyc(1'b0, 1'b0, 1'b1, 10'd12, 8'h96, 1'b1, 12'h801);
    model[12] = tb_encode(8'h96);
    do_read("R10 write wins", 10'd12);
    do_inject(10'd12, 12'h801);
    do_read("R10 inject applied", 10'd12);

    // random traffic over reused addresses
    for (int a = 0; a < 16; a++) do_write(a[AW-1:0], 8'($urandom), 1'b1);
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] ra;
      int op;
      int b0;
      int b1;
      ra = AW'($urandom % 16);
      op = int'($urandom % 5);
      b0 = int'($urandom % 12);
      b1 = int'($urandom % 12);
      case (op)
        0: do_write(ra, 8'($urandom), 1'($urandom));
        1: begin
             do_write(ra, 8'($urandom), 1'b1);
             do_inject(ra, 12'(1) << b0);
             do_read("R2 random single", ra);
           end
        2: begin
             do_inject(ra, 12'(1) << b0);
             do_read("R3 random stack", ra);
             if (b1 != b0) do_inject(ra, 12'(1) << b1);
           end
        default: do_read("R6 random read", ra);
      endcase
    end
    cyc(1'b1, 1'b1, 1'b0, 10'd0, 8'h00, 1'b0, '0);
    chk_bit("R5 final deselect", dq_oe, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule